// File: doc/BRIEF.md
# USB Endpoint Handshake Mode Controller

This block decides how one USB function endpoint answers each token that reaches it. A token decoder upstream presents the token kind and its target address. A receive path reports the end of the data packet that follows a SETUP or OUT token, together with its CRC status and byte count. A transmit path reports the host's ACK after the endpoint has sent data. The block answers with a single response choice: ACK, NAK, STALL, a data packet, a zero-length data packet, or nothing at all. The serializer then turns that choice into a packet.

The answer policy comes from a 4-bit mode code that firmware loads into the endpoint's mode register. Hardware updates that register and a count/toggle register as transactions complete. On a control endpoint, three extra mode-register bits record which kinds of token were seen. A device-address register with an enable bit gates every answer. After an accepted SETUP or OUT, hardware drops the endpoint into a NAK mode, so firmware has to re-arm it before more data is taken.

Top module: `ep_hshk_ctrl`

## Requirements
- R1: During reset the device-address register, mode register and count register read 0, and `resp_valid` is 0.
- R2: A token is considered only when bit 7 of the device-address register is 1 and `tok_addr` equals its bits [6:0]. Any other token produces no response and changes no register.
- R3: The token kind is encoded 01 = SETUP, 10 = IN, 11 = OUT. IN tokens are answered directly from the mode code in `mode_q[3:0]`, and the response is encoded on `resp_code` as 1 = ACK, 2 = NAK, 3 = STALL, 4 = data, 5 = zero-length data. Modes 1, 0Ch and 0Eh give NAK. Modes 2 and 3 give STALL. Modes 6, 0Ah and 0Bh give zero-length data. Modes 7, 0Dh and 0Fh give data. All other modes give no response.
- R4: For an OUT token followed by a good data packet, the endpoint answers NAK in modes 1, 8 and 0Ah, STALL in modes 3 and 6, and ACK in modes 2, 9, 0Bh, 0Eh and 0Fh. A NAK or STALL leaves the count register unchanged.
- R5: On this control endpoint a SETUP token followed by a good data packet is answered with ACK in modes 1, 2, 3, 4, 6, 0Ah, 0Bh, 0Eh and 0Fh. It sets the toggle bit `cnt_q[5]`, stores the count with the valid bit `cnt_q[4]` set, sets the acknowledge bit `mode_q[4]`, and loads mode 1. In the other modes SETUP gets no response.
- R6: An ACKed OUT inverts the toggle bit, stores `rx_len` in `cnt_q[3:0]` with the valid bit set, sets `mode_q[4]`, and rewrites the mode 2→1, 9→8, 0Bh→0Ah, 0Fh→0Eh (0Eh stays 0Eh).
- R7: A data packet with a CRC error after an accepted SETUP or OUT gets no response. It clears the valid bit and leaves the mode register unchanged.
- R8: After a data or zero-length answer in a non-isochronous mode, a host ACK sets `mode_q[4]` and inverts the toggle bit. After an isochronous IN (mode 7) the host-ACK input is ignored.
- R9: In mode 5 (isochronous OUT) a good data packet is stored (count loaded, valid bit set), gets no response, and leaves the toggle bit and mode code unchanged.
- R10: On this control endpoint, `mode_q[7]`, `mode_q[6]` and `mode_q[5]` are set when a SETUP, IN or OUT token (respectively) is answered or stored, and a firmware write of the mode register replaces them.
- R11: In mode 0, and for every token a mode does not answer, there is no response, and the data packet that follows changes no register.
- R12: `resp_valid` rises on the first clock edge after the token (IN) or after `rx_done` (SETUP/OUT) and stays high for one cycle.
- R13: A new token abandons a pending SETUP/OUT data phase, so a later `rx_done` gets no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_wr | input | 1 | Firmware write strobe for the device-address register |
| addr_wdata | input | 8 | Address write data: enable in bit 7, address in [6:0] |
| mode_wr | input | 1 | Firmware write strobe for the mode register |
| mode_wdata | input | 8 | Mode write data |
| cnt_wr | input | 1 | Firmware write strobe for the count register |
| cnt_wdata | input | 6 | Count write data: toggle [5], valid [4], count [3:0] |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | Token kind (01 SETUP, 10 IN, 11 OUT) |
| tok_addr | input | 7 | Device address carried by the token |
| rx_done | input | 1 | End of the data packet after SETUP/OUT |
| rx_crc_ok | input | 1 | CRC of that data packet was good |
| rx_len | input | 4 | Byte count of that data packet |
| host_ack | input | 1 | Host ACK received after the endpoint sent data |
| resp_valid | output | 1 | One-cycle strobe: a handshake or data response is requested |
| resp_code | output | 3 | Response kind (1 ACK, 2 NAK, 3 STALL, 4 data, 5 zero-length) |
| dev_addr_q | output | 8 | Device-address register contents |
| mode_q | output | 8 | Mode register: flags [7:5], acknowledge [4], mode code [3:0] |
| cnt_q | output | 6 | Count register: toggle [5], valid [4], count [3:0] |

## Verification
The main function is swept over all sixteen mode codes against each of the three token kinds. Every pairing starts from a known count and flag state, so the bench can tell an ACK from a NAK or STALL, data from zero-length data, an isochronous store from an ignore, and a SETUP toggle set from an OUT toggle flip by the exact register values left behind. Separate patterns cover these cases:
- a disabled address and a mismatched address;
- a CRC error on a previously valid count;
- a token that interrupts a pending data phase;
- a host ACK arriving after an isochronous IN, where it must be ignored.

Together these patterns separate the gating, discard and abort paths from ordinary responses.

// File: rtl/ep_hshk_pkg.sv
// Shared types and helpers for the endpoint handshake controller.
// Assumes a 2-bit token kind and a 3-bit response code as listed in the brief.
package ep_hshk_pkg;

    typedef enum logic [1:0] {
        TK_NONE  = 2'b00,
        TK_SETUP = 2'b01,
        TK_IN    = 2'b10,
        TK_OUT   = 2'b11
    } tok_kind_e;

    // Internal decision for one token under the current mode code.
    typedef enum logic [2:0] {
        ACT_IGN    = 3'd0,
        ACT_ACK    = 3'd1,
        ACT_NAK    = 3'd2,
        ACT_STALL  = 3'd3,
        ACT_DATA   = 3'd4,
        ACT_ZLEN   = 3'd5,
        ACT_ISO_TX = 3'd6,
        ACT_ISO_RX = 3'd7
    } act_e;

    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_ACK   = 3'd1,
        RSP_NAK   = 3'd2,
        RSP_STALL = 3'd3,
        RSP_DATA  = 3'd4,
        RSP_ZLEN  = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_RX,
        ST_WAIT_HACK
    } st_e;

    // Mode code an endpoint falls back to after it has ACKed OUT data.
    function automatic logic [3:0] nak_of(input logic [3:0] m);
        case (m)
            4'h2:    nak_of = 4'h1;
            4'h9:    nak_of = 4'h8;
            4'hB:    nak_of = 4'hA;
            4'hF:    nak_of = 4'hE;
            default: nak_of = m;
        endcase
    endfunction

    // Wire-level response for an action; no-handshake actions map to none.
    function automatic rsp_e to_rsp(input act_e a);
        case (a)
            ACT_ACK:    to_rsp = RSP_ACK;
            ACT_NAK:    to_rsp = RSP_NAK;
            ACT_STALL:  to_rsp = RSP_STALL;
            ACT_DATA:   to_rsp = RSP_DATA;
            ACT_ISO_TX: to_rsp = RSP_DATA;
            ACT_ZLEN:   to_rsp = RSP_ZLEN;
            default:    to_rsp = RSP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ep_addr_filter.sv
// Device-address register and token address match.
// Holds {enable, address}; a token hits only while enable is set and the
// address fields agree. Firmware loads the register through wr/wdata.
module ep_addr_filter #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W:0]   wdata,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic [ADDR_W:0]   reg_q,
    output logic              hit
);
    localparam int EN_BIT = ADDR_W;

    // Address register: cleared at reset, loaded by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n)  reg_q <= '0;
        else if (wr) reg_q <= wdata;
    end

    // Token match against the enabled address.
    assign hit = reg_q[EN_BIT] && (tok_addr == reg_q[ADDR_W-1:0]);

endmodule

// File: rtl/ep_mode_policy.sv
// Combinational answer policy: maps the 4-bit mode code and a token kind
// to an action. SETUP is accepted only when CTRL_EP is nonzero.
module ep_mode_policy
    import ep_hshk_pkg::*;
#(
    parameter int CTRL_EP = 1
) (
    input  logic [3:0] mode_nib,
    input  tok_kind_e  kind,
    output act_e       act
);
    logic setup_ok;
    act_e setup_act;
    act_e in_act;
    act_e out_act;

    // Per-direction policy tables.
    always_comb begin
        setup_ok = 1'b0;
        in_act   = ACT_IGN;
        out_act  = ACT_IGN;
        case (mode_nib)
            4'h1: begin setup_ok = 1'b1; in_act = ACT_NAK;    out_act = ACT_NAK;    end
            4'h2: begin setup_ok = 1'b1; in_act = ACT_STALL;  out_act = ACT_ACK;    end
            4'h3: begin setup_ok = 1'b1; in_act = ACT_STALL;  out_act = ACT_STALL;  end
            4'h4: begin setup_ok = 1'b1;                                            end
            4'h5: begin                                       out_act = ACT_ISO_RX; end
            4'h6: begin setup_ok = 1'b1; in_act = ACT_ZLEN;   out_act = ACT_STALL;  end
            4'h7: begin                  in_act = ACT_ISO_TX;                       end
            4'h8: begin                                       out_act = ACT_NAK;    end
            4'h9: begin                                       out_act = ACT_ACK;    end
            4'hA: begin setup_ok = 1'b1; in_act = ACT_ZLEN;   out_act = ACT_NAK;    end
            4'hB: begin setup_ok = 1'b1; in_act = ACT_ZLEN;   out_act = ACT_ACK;    end
            4'hC: begin                  in_act = ACT_NAK;                          end
            4'hD: begin                  in_act = ACT_DATA;                         end
            4'hE: begin setup_ok = 1'b1; in_act = ACT_NAK;    out_act = ACT_ACK;    end
            4'hF: begin setup_ok = 1'b1; in_act = ACT_DATA;   out_act = ACT_ACK;    end
            default: ;
        endcase
    end

    generate
        if (CTRL_EP != 0) begin : g_ctrl
            assign setup_act = setup_ok ? ACT_ACK : ACT_IGN;
        end else begin : g_plain
            assign setup_act = ACT_IGN;
        end
    endgenerate

    // Select by token kind.
    always_comb begin
        case (kind)
            TK_SETUP: act = setup_act;
            TK_IN:    act = in_act;
            TK_OUT:   act = out_act;
            default:  act = ACT_IGN;
        endcase
    end

endmodule

// File: rtl/ep_status_regs.sv
// Mode and count/toggle registers. A firmware write takes priority over
// hardware update strobes in the same cycle. Token flags exist only when
// CTRL_EP is nonzero; otherwise they read zero.
module ep_status_regs #(
    parameter int CNT_W   = 4,
    parameter int CTRL_EP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [7:0]       mode_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W+1:0] cnt_wdata,
    input  logic [2:0]       flag_set,
    input  logic             ack_set,
    input  logic             nib_load,
    input  logic [3:0]       nib_val,
    input  logic             rx_store,
    input  logic [CNT_W-1:0] rx_len,
    input  logic             tog_one,
    input  logic             tog_flip,
    input  logic             valid_clr,
    output logic [7:0]       mode_q,
    output logic [CNT_W+1:0] cnt_q
);
    localparam int TOG_BIT = CNT_W + 1;
    localparam int VLD_BIT = CNT_W;

    logic [2:0]       flags;
    logic             ack_q;
    logic [3:0]       nib_q;
    logic             tog_q;
    logic             vld_q;
    logic [CNT_W-1:0] len_q;

    // Acknowledge bit and mode code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            nib_q <= 4'h0;
        end else if (mode_wr) begin
            ack_q <= mode_wdata[4];
            nib_q <= mode_wdata[3:0];
        end else begin
            if (ack_set)  ack_q <= 1'b1;
            if (nib_load) nib_q <= nib_val;
        end
    end

    generate
        if (CTRL_EP != 0) begin : g_flags
            // Sticky token-seen flags, replaced by a firmware write.
            always_ff @(posedge clk) begin
                if (!rst_n)       flags <= 3'b000;
                else if (mode_wr) flags <= mode_wdata[7:5];
                else              flags <= flags | flag_set;
            end
        end else begin : g_noflags
            assign flags = 3'b000;
        end
    endgenerate

    // Toggle, valid and byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
            vld_q <= 1'b0;
            len_q <= '0;
        end else if (cnt_wr) begin
            tog_q <= cnt_wdata[TOG_BIT];
            vld_q <= cnt_wdata[VLD_BIT];
            len_q <= cnt_wdata[CNT_W-1:0];
        end else begin
            if (tog_one)       tog_q <= 1'b1;
            else if (tog_flip) tog_q <= ~tog_q;
            if (rx_store) begin
                vld_q <= 1'b1;
                len_q <= rx_len;
            end else if (valid_clr) begin
                vld_q <= 1'b0;
            end
        end
    end

    assign mode_q = {flags, ack_q, nib_q};
    assign cnt_q  = {tog_q, vld_q, len_q};

endmodule

// File: rtl/ep_hshk_ctrl.sv
// Endpoint handshake controller top. Takes decoded tokens, data-phase
// completion and host ACK, and issues a registered one-cycle response.
// Assumes at most one event source matters per cycle: a token takes
// priority over rx_done/host_ack and abandons any pending phase.
module ep_hshk_ctrl
    import ep_hshk_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int CNT_W   = 4,
    parameter int CTRL_EP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [ADDR_W:0]   addr_wdata,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W+1:0]  cnt_wdata,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic              rx_done,
    input  logic              rx_crc_ok,
    input  logic [CNT_W-1:0]  rx_len,
    input  logic              host_ack,
    output logic              resp_valid,
    output logic [2:0]        resp_code,
    output logic [ADDR_W:0]   dev_addr_q,
    output logic [7:0]        mode_q,
    output logic [CNT_W+1:0]  cnt_q
);
    localparam int FL_SETUP = 2;
    localparam int FL_IN    = 1;
    localparam int FL_OUT   = 0;

    tok_kind_e kind;
    logic      hit;
    act_e      tok_act;

    st_e        st_q, st_d;
    act_e       pend_act_q;
    logic [3:0] pend_nib_q;
    logic       pend_setup_q;
    logic       latch_pend;

    logic       rv_d, rv_q;
    rsp_e       rsp_d, rsp_q;

    logic [2:0] flag_set;
    logic       ack_set, nib_load, rx_store, tog_one, tog_flip, valid_clr;
    logic [3:0] nib_val;

    assign kind = tok_kind_e'(tok_kind);

    ep_addr_filter #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (addr_wr),
        .wdata    (addr_wdata),
        .tok_addr (tok_addr),
        .reg_q    (dev_addr_q),
        .hit      (hit)
    );

    ep_mode_policy #(.CTRL_EP(CTRL_EP)) u_policy (
        .mode_nib (mode_q[3:0]),
        .kind     (kind),
        .act      (tok_act)
    );

    ep_status_regs #(.CNT_W(CNT_W), .CTRL_EP(CTRL_EP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .flag_set   (flag_set),
        .ack_set    (ack_set),
        .nib_load   (nib_load),
        .nib_val    (nib_val),
        .rx_store   (rx_store),
        .rx_len     (rx_len),
        .tog_one    (tog_one),
        .tog_flip   (tog_flip),
        .valid_clr  (valid_clr),
        .mode_q     (mode_q),
        .cnt_q      (cnt_q)
    );

    // Transaction sequencing and register-update strobes.
    always_comb begin
        st_d       = st_q;
        rv_d       = 1'b0;
        rsp_d      = RSP_NONE;
        latch_pend = 1'b0;
        flag_set   = 3'b000;
        ack_set    = 1'b0;
        nib_load   = 1'b0;
        nib_val    = 4'h0;
        rx_store   = 1'b0;
        tog_one    = 1'b0;
        tog_flip   = 1'b0;
        valid_clr  = 1'b0;
        if (tok_valid) begin
            st_d = ST_IDLE;
            if (hit && tok_act != ACT_IGN) begin
                if (kind == TK_IN) begin
                    rv_d            = 1'b1;
                    rsp_d           = to_rsp(tok_act);
                    flag_set[FL_IN] = 1'b1;
                    if (tok_act == ACT_DATA || tok_act == ACT_ZLEN) st_d = ST_WAIT_HACK;
                end else begin
                    latch_pend = 1'b1;
                    st_d       = ST_WAIT_RX;
                end
            end
        end else begin
            case (st_q)
                ST_WAIT_RX: begin
                    if (rx_done) begin
                        st_d = ST_IDLE;
                        if (!rx_crc_ok) begin
                            valid_clr = 1'b1;
                        end else begin
                            if (pend_setup_q) flag_set[FL_SETUP] = 1'b1;
                            else              flag_set[FL_OUT]   = 1'b1;
                            rsp_d = to_rsp(pend_act_q);
                            rv_d  = (pend_act_q != ACT_ISO_RX);
                            if (pend_act_q == ACT_ACK || pend_act_q == ACT_ISO_RX) rx_store = 1'b1;
                            if (pend_act_q == ACT_ACK) begin
                                ack_set  = 1'b1;
                                nib_load = 1'b1;
                                if (pend_setup_q) begin
                                    tog_one = 1'b1;
                                    nib_val = 4'h1;
                                end else begin
                                    tog_flip = 1'b1;
                                    nib_val  = nak_of(pend_nib_q);
                                end
                            end
                        end
                    end
                end
                ST_WAIT_HACK: begin
                    if (host_ack) begin
                        st_d     = ST_IDLE;
                        ack_set  = 1'b1;
                        tog_flip = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State, pending-token context and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            pend_act_q   <= ACT_IGN;
            pend_nib_q   <= 4'h0;
            pend_setup_q <= 1'b0;
            rv_q         <= 1'b0;
            rsp_q        <= RSP_NONE;
        end else begin
            st_q  <= st_d;
            rv_q  <= rv_d;
            rsp_q <= rsp_d;
            if (latch_pend) begin
                pend_act_q   <= tok_act;
                pend_nib_q   <= mode_q[3:0];
                pend_setup_q <= (kind == TK_SETUP);
            end
        end
    end

    assign resp_valid = rv_q;
    assign resp_code  = rsp_q;

endmodule

// File: rtl/ep_hshk_ctrl_chk.sv
// Checker for ep_hshk_ctrl, attached by bind. Observes ports only.
module ep_hshk_ctrl_chk #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [ADDR_W-1:0] tok_addr,
    input logic              rx_done,
    input logic              rx_crc_ok,
    input logic              mode_wr,
    input logic              cnt_wr,
    input logic              resp_valid,
    input logic [2:0]        resp_code,
    input logic [ADDR_W:0]   dev_addr_q,
    input logic [7:0]        mode_q,
    input logic [CNT_W+1:0]  cnt_q
);
    localparam int TOG_BIT = CNT_W + 1;
    localparam int VLD_BIT = CNT_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && cnt_q == '0 && dev_addr_q == '0 && !resp_valid));

    assert_addr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !(dev_addr_q[ADDR_W] && tok_addr == dev_addr_q[ADDR_W-1:0]))
        |=> !resp_valid);

    assert_setup_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_q[7]) && !$past(mode_wr) && !$past(cnt_wr)) |-> cnt_q[TOG_BIT]);

    assert_crc_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_crc_ok && !tok_valid && !cnt_wr) |=> (!resp_valid && !cnt_q[VLD_BIT]));

    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && mode_q[3:0] == 4'h0) |=> !resp_valid);

    assert_resp_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(tok_valid || rx_done));

    assert_resp_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code >= 3'd1 && resp_code <= 3'd5));

endmodule

bind ep_hshk_ctrl ep_hshk_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_addr   (tok_addr),
    .rx_done    (rx_done),
    .rx_crc_ok  (rx_crc_ok),
    .mode_wr    (mode_wr),
    .cnt_wr     (cnt_wr),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .dev_addr_q (dev_addr_q),
    .mode_q     (mode_q),
    .cnt_q      (cnt_q)
);

// File: tb/ep_hshk_ctrl_test.sv
module ep_hshk_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr = 1'b0;
    logic [7:0] addr_wdata = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       cnt_wr = 1'b0;
    logic [5:0] cnt_wdata = '0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = '0;
    logic [6:0] tok_addr = '0;
    logic       rx_done = 1'b0;
    logic       rx_crc_ok = 1'b0;
    logic [3:0] rx_len = '0;
    logic       host_ack = 1'b0;
    logic       resp_valid;
    logic [2:0] resp_code;
    logic [7:0] dev_addr_q;
    logic [7:0] mode_q;
    logic [5:0] cnt_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [6:0] MY_ADDR = 7'h2A;

    ep_hshk_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_addr(tok_addr),
        .rx_done(rx_done), .rx_crc_ok(rx_crc_ok), .rx_len(rx_len),
        .host_ack(host_ack),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .dev_addr_q(dev_addr_q), .mode_q(mode_q), .cnt_q(cnt_q)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int resp_now();
        return resp_valid ? int'(resp_code) : 0;
    endfunction

    // Expected action: 0 none,1 ACK,2 NAK,3 STALL,4 data,5 zero-len,6 iso tx,7 iso rx
    function automatic int exp_act(input int m, input int k);
        int a = 0;
        if (k == 1) begin
            if (m inside {1, 2, 3, 4, 6, 10, 11, 14, 15}) a = 1;
        end else if (k == 2) begin
            case (m)
                1, 12, 14:  a = 2;
                2, 3:       a = 3;
                6, 10, 11:  a = 5;
                7:          a = 6;
                13, 15:     a = 4;
                default:    a = 0;
            endcase
        end else begin
            case (m)
                1, 8, 10:           a = 2;
                3, 6:               a = 3;
                2, 9, 11, 14, 15:   a = 1;
                5:                  a = 7;
                default:            a = 0;
            endcase
        end
        return a;
    endfunction

    function automatic int nak_mode(input int m);
        case (m)
            2:  return 1;
            9:  return 8;
            11: return 10;
            15: return 14;
            default: return m;
        endcase
    endfunction

    task automatic arm(input logic [7:0] m, input logic [5:0] c);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m; cnt_wr = 1'b1; cnt_wdata = c;
        @(negedge clk);
        mode_wr = 1'b0; cnt_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        @(negedge clk);
        addr_wr = 1'b1; addr_wdata = a;
        @(negedge clk);
        addr_wr = 1'b0;
    endtask

    task automatic send_tok(input logic [1:0] k, input logic [6:0] a);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = k; tok_addr = a;
        @(negedge clk);
        tok_valid = 1'b0; tok_kind = 2'b00;
    endtask

    task automatic send_rx(input logic ok, input logic [3:0] n);
        @(negedge clk);
        rx_done = 1'b1; rx_crc_ok = ok; rx_len = n;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic send_hack();
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mode", mode_q, 0);
        chk("R1 cnt", cnt_q, 0);
        chk("R1 addr", dev_addr_q, 0);
        chk("R1 resp", resp_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: address disabled, then mismatched, then matching
        arm(8'h0D, 6'h20);
        set_addr({1'b0, MY_ADDR});
        send_tok(2'b10, MY_ADDR);
        chk("R2 disabled resp", resp_now(), 0);
        chk("R2 disabled mode", mode_q, 8'h0D);
        set_addr({1'b1, MY_ADDR});
        send_tok(2'b10, MY_ADDR + 7'd1);
        chk("R2 mismatch resp", resp_now(), 0);
        chk("R2 mismatch mode", mode_q, 8'h0D);
        send_tok(2'b10, MY_ADDR);
        chk("R2 match resp", resp_now(), 4);
        @(negedge clk);
        chk("R12 single pulse", resp_valid, 0);
        send_hack();

        // Exhaustive sweep: all modes x all token kinds
        for (int m = 0; m < 16; m++) begin
            for (int k = 1; k < 4; k++) begin
                int a;
                int fl;
                a = exp_act(m, k);
                arm(8'(m), 6'h20);
                send_tok(2'(k), MY_ADDR);
                if (k == 2) begin
                    chk($sformatf("R3 IN resp m=%0h", m), resp_now(), (a == 6) ? 4 : a);
                    fl = (a != 0) ? 8'h40 : 0;
                    chk($sformatf("R10 IN flag m=%0h", m), mode_q, fl | m);
                    if (a == 4 || a == 5) begin
                        send_hack();
                        chk($sformatf("R8 ack bit m=%0h", m), mode_q, fl | 8'h10 | m);
                        chk($sformatf("R8 toggle m=%0h", m), cnt_q, 6'h00);
                    end else if (a == 6) begin
                        send_hack();
                        chk($sformatf("R8 iso ignore mode m=%0h", m), mode_q, fl | m);
                        chk($sformatf("R8 iso ignore cnt m=%0h", m), cnt_q, 6'h20);
                    end else if (a == 0) begin
                        chk($sformatf("R11 IN cnt m=%0h", m), cnt_q, 6'h20);
                    end
                end else begin
                    chk($sformatf("R12 no early resp m=%0h k=%0d", m, k), resp_now(), 0);
                    send_rx(1'b1, 4'd5);
                    if (a == 1 && k == 1) begin
                        chk($sformatf("R5 resp m=%0h", m), resp_now(), 1);
                        chk($sformatf("R5 mode m=%0h", m), mode_q, 8'h91);
                        chk($sformatf("R5 cnt m=%0h", m), cnt_q, 6'h35);
                    end else if (a == 1) begin
                        chk($sformatf("R4 resp m=%0h", m), resp_now(), 1);
                        chk($sformatf("R6 mode m=%0h", m), mode_q, 8'h30 | nak_mode(m));
                        chk($sformatf("R6 cnt m=%0h", m), cnt_q, 6'h15);
                    end else if (a == 2 || a == 3) begin
                        chk($sformatf("R4 resp m=%0h", m), resp_now(), a);
                        chk($sformatf("R10 OUT flag m=%0h", m), mode_q, 8'h20 | m);
                        chk($sformatf("R4 cnt kept m=%0h", m), cnt_q, 6'h20);
                    end else if (a == 7) begin
                        chk($sformatf("R9 resp m=%0h", m), resp_now(), 0);
                        chk($sformatf("R9 mode m=%0h", m), mode_q, 8'h20 | m);
                        chk($sformatf("R9 cnt m=%0h", m), cnt_q, 6'h35);
                    end else begin
                        chk($sformatf("R11 resp m=%0h k=%0d", m, k), resp_now(), 0);
                        chk($sformatf("R11 mode m=%0h k=%0d", m, k), mode_q, m);
                        chk($sformatf("R11 cnt m=%0h k=%0d", m, k), cnt_q, 6'h20);
                    end
                end
            end
        end

        // R7: CRC error on OUT and on SETUP
        arm(8'h0B, 6'h33);
        send_tok(2'b11, MY_ADDR);
        send_rx(1'b0, 4'd7);
        chk("R7 OUT resp", resp_now(), 0);
        chk("R7 OUT cnt", cnt_q, 6'h23);
        chk("R7 OUT mode", mode_q, 8'h0B);
        arm(8'h0F, 6'h13);
        send_tok(2'b01, MY_ADDR);
        send_rx(1'b0, 4'd2);
        chk("R7 SETUP resp", resp_now(), 0);
        chk("R7 SETUP mode", mode_q, 8'h0F);
        chk("R7 SETUP cnt", cnt_q, 6'h03);

        // R13: a token abandons the pending OUT data phase
        arm(8'h09, 6'h20);
        send_tok(2'b11, MY_ADDR);
        send_tok(2'b10, MY_ADDR);
        chk("R13 ignored IN resp", resp_now(), 0);
        send_rx(1'b1, 4'd9);
        chk("R13 resp", resp_now(), 0);
        chk("R13 cnt", cnt_q, 6'h20);
        chk("R13 mode", mode_q, 8'h09);

        // R10: firmware write replaces flags
        arm(8'h40, 6'h00);
        chk("R10 flag write", mode_q, 8'h40);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule